// File: doc/BRIEF.md
# DMA Command Decoder and Readback Sequencer

This block is the command and readback front end of a two-port DMA controller. The CPU writes 8-bit command codes into a single write port. Each accepted code is decoded into control effects: the DMA enable, the interrupt enable, the interrupt pending and in-service flags, one-cycle strobes for load, continue, force ready and the two port timing resets, and changes to the readback state. A special command makes the following written byte a read mask rather than a command.

The CPU reads back seven bytes on a separate output stream: a status byte, the two bytes of the byte counter and the low and high bytes of the port A and port B addresses. The counter and addresses come from a datapath stub as plain inputs. The mask picks which of these bytes take part, and each read steps to the next selected byte, wrapping around.

Both interfaces use valid/ready. The command port always asserts `cmd_ready`, so a byte is taken on every clock edge where `cmd_valid` is high. The readback port holds `rb_valid` high from the first edge after reset. `rb_data` is stable until the CPU consumes it with `rb_ready`, and a byte is popped only on an edge where both are high. The CPU may hold `rb_ready` low for any length of time.

Top module: `dma_cmd_seq`

## Requirements
- R1: After reset `dma_en`, `int_en`, `int_pend`, `int_ius` and all strobes are 0. The status byte reads 0x00. The mask selects all seven bytes, and the readback pointer is on the status byte.
- R2: Code 0x87 sets `dma_en` and code 0x83 clears it. Each takes effect in the cycle after the write.
- R3: Each of these codes gives a strobe that is high only in the cycle after the write: 0xCF `load_stb`, 0xD3 `cont_stb`, 0xB3 `force_rdy_stb`, 0xC7 `rst_a_tim_stb`, 0xCB `rst_b_tim_stb`.
- R4: Code 0xAB sets `int_en` and leaves `int_pend` and `int_ius` unchanged. Code 0xAF clears `int_en`.
- R5: `int_req` sets `int_pend` when `int_en` is 1. `int_ack` while `int_pend` is 1 clears `int_pend` and sets `int_ius`.
- R6: Code 0xA3 clears `int_pend`, `int_ius` and `int_en`. Code 0xB7 clears `int_ius`, sets `int_en` and leaves `int_pend` unchanged.
- R7: After code 0xBB, the next written byte is stored as the mask, using bits 0 to 6, and is not decoded as a command. The readback pointer then moves to the lowest selected byte.
- R8: Readback order is fixed, with mask bit i selecting position i. Positions 0 to 6 are: status, counter low, counter high, port A low, port A high, port B low, port B high. Each pop moves the pointer to the next selected position and wraps past position 6.
- R9: Code 0xA7 returns the pointer to the lowest selected position.
- R10: After code 0xBF, the next pop returns the status byte and leaves the pointer where it was.
- R11: With a mask of all zeros, every read returns the status byte.
- R12: Code 0x8B loads the status byte from `status_in`.
- R13: Code 0xC3 clears `dma_en`, `int_en`, `int_pend` and `int_ius`. It also restores the mask to all seven bytes and puts the pointer back on the status byte. The status byte keeps its value.
- R14: Any code not listed above changes no output and no readback state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command byte valid |
| cmd_ready | output | 1 | Command port ready (always 1 outside reset) |
| cmd_data | input | 8 | Command code or mask byte |
| rb_valid | output | 1 | Readback byte valid |
| rb_ready | input | 1 | Readback byte consumed |
| rb_data | output | 8 | Readback byte |
| status_in | input | 8 | Live status from the datapath |
| byte_cnt | input | 16 | Byte counter from the datapath |
| addr_a | input | 16 | Port A address |
| addr_b | input | 16 | Port B address |
| int_req | input | 1 | Interrupt request from the transfer engine |
| int_ack | input | 1 | Interrupt acknowledge |
| dma_en | output | 1 | DMA enable |
| int_en | output | 1 | Interrupt enable |
| int_pend | output | 1 | Interrupt pending |
| int_ius | output | 1 | Interrupt under service |
| load_stb | output | 1 | Load strobe |
| cont_stb | output | 1 | Continue strobe |
| force_rdy_stb | output | 1 | Force ready strobe |
| rst_a_tim_stb | output | 1 | Port A timing reset strobe |
| rst_b_tim_stb | output | 1 | Port B timing reset strobe |

## Verification
The hardest case to reach is a sparse mask combined with a forced status read while the pointer sits part way through the sequence. Only a wrong pointer update would show up there. The stimulus loads a mask with gaps and pops into the middle of the sequence. It then issues the force-status code and confirms that the next pop returns status and the one after it resumes at the same position. A mask byte whose top bit makes it look like a DMA enable code checks that the mask write escapes decoding.

// File: rtl/dma_cmd_pkg.sv
package dma_cmd_pkg;
  localparam int NSLOT = 7;
  localparam int PW    = 3;

  typedef enum logic [7:0] {
    OP_RESET      = 8'hC3,
    OP_RST_A_TIM  = 8'hC7,
    OP_RST_B_TIM  = 8'hCB,
    OP_LOAD       = 8'hCF,
    OP_CONT       = 8'hD3,
    OP_INT_OFF    = 8'hAF,
    OP_INT_ON     = 8'hAB,
    OP_INT_CLR    = 8'hA3,
    OP_INT_RETI   = 8'hB7,
    OP_RD_STAT    = 8'hBF,
    OP_REINIT_ST  = 8'h8B,
    OP_INIT_RD    = 8'hA7,
    OP_FORCE_RDY  = 8'hB3,
    OP_DMA_ON     = 8'h87,
    OP_DMA_OFF    = 8'h83,
    OP_MASK_NEXT  = 8'hBB
  } opcode_e;

  typedef struct packed {
    logic rst_all;
    logic rst_a;
    logic rst_b;
    logic load;
    logic cont;
    logic int_off;
    logic int_on;
    logic int_clr;
    logic int_reti;
    logic rd_stat;
    logic reinit_st;
    logic init_rd;
    logic force_rdy;
    logic dma_on;
    logic dma_off;
    logic mask_next;
  } cmd_t;

  function automatic logic [PW-1:0] first_sel(input logic [NSLOT-1:0] m);
    logic [PW-1:0] r;
    r = '0;
    for (int i = NSLOT-1; i >= 0; i--)
      if (m[i]) r = PW'(i);
    return r;
  endfunction

  function automatic logic [PW-1:0] next_sel(input logic [NSLOT-1:0] m,
                                             input logic [PW-1:0] p);
    logic [PW-1:0] r;
    int unsigned idx;
    r = p;
    for (int k = NSLOT-1; k >= 1; k--) begin
      idx = (int'(p) + k) % NSLOT;
      if (m[idx]) r = PW'(idx);
    end
    return r;
  endfunction
endpackage

// File: rtl/dma_cmd_decode.sv
module dma_cmd_decode
  import dma_cmd_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          en,
  input  logic [DW-1:0] code,
  output cmd_t          cmd
);
  always_comb begin
    cmd = '0;
    if (en) begin
      case (code)
        OP_RESET:     cmd.rst_all   = 1'b1;
        OP_RST_A_TIM: cmd.rst_a     = 1'b1;
        OP_RST_B_TIM: cmd.rst_b     = 1'b1;
        OP_LOAD:      cmd.load      = 1'b1;
        OP_CONT:      cmd.cont      = 1'b1;
        OP_INT_OFF:   cmd.int_off   = 1'b1;
        OP_INT_ON:    cmd.int_on    = 1'b1;
        OP_INT_CLR:   cmd.int_clr   = 1'b1;
        OP_INT_RETI:  cmd.int_reti  = 1'b1;
        OP_RD_STAT:   cmd.rd_stat   = 1'b1;
        OP_REINIT_ST: cmd.reinit_st = 1'b1;
        OP_INIT_RD:   cmd.init_rd   = 1'b1;
        OP_FORCE_RDY: cmd.force_rdy = 1'b1;
        OP_DMA_ON:    cmd.dma_on    = 1'b1;
        OP_DMA_OFF:   cmd.dma_off   = 1'b1;
        OP_MASK_NEXT: cmd.mask_next = 1'b1;
        default:      cmd = '0;
      endcase
    end
  end
endmodule

// File: rtl/dma_int_flags.sv
module dma_int_flags
  import dma_cmd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cmd_t cmd,
  input  logic int_req,
  input  logic int_ack,
  output logic int_en,
  output logic int_pend,
  output logic int_ius
);
  logic clr_all;
  assign clr_all = cmd.rst_all | cmd.int_clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_en   <= 1'b0;
      int_pend <= 1'b0;
      int_ius  <= 1'b0;
    end else begin
      if (clr_all || cmd.int_off)                  int_en <= 1'b0;
      else if (cmd.int_on || cmd.int_reti)         int_en <= 1'b1;

      if (clr_all)                                 int_pend <= 1'b0;
      else if (int_ack && int_pend)                int_pend <= 1'b0;
      else if (int_req && int_en)                  int_pend <= 1'b1;

      if (clr_all || cmd.int_reti)                 int_ius <= 1'b0;
      else if (int_ack && int_pend)                int_ius <= 1'b1;
    end
  end
endmodule

// File: rtl/dma_rb_seq.sv
module dma_rb_seq
  import dma_cmd_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  cmd_t                      cmd,
  input  logic                      mask_load,
  input  logic [DW-1:0]             mask_val,
  input  logic                      pop,
  input  logic [NSLOT-1:0][DW-1:0]  slots,
  output logic [DW-1:0]             rd_byte
);
  logic [NSLOT-1:0] mask_q;
  logic [PW-1:0]    ptr_q;
  logic             force_q;

  always_ff @(posedge clk) begin
    if (!rst_n || cmd.rst_all) begin
      mask_q  <= '1;
      ptr_q   <= '0;
      force_q <= 1'b0;
    end else begin
      if (mask_load) begin
        mask_q <= mask_val[NSLOT-1:0];
        ptr_q  <= first_sel(mask_val[NSLOT-1:0]);
      end else if (cmd.init_rd) begin
        ptr_q  <= first_sel(mask_q);
      end else if (pop && !force_q && (mask_q != '0)) begin
        ptr_q  <= next_sel(mask_q, ptr_q);
      end

      if (cmd.rd_stat)  force_q <= 1'b1;
      else if (pop)     force_q <= 1'b0;
    end
  end

  assign rd_byte = (force_q || mask_q == '0) ? slots[0] : slots[ptr_q];
endmodule

// File: rtl/dma_cmd_seq.sv
module dma_cmd_seq
  import dma_cmd_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [DW-1:0] cmd_data,
  output logic          rb_valid,
  input  logic          rb_ready,
  output logic [DW-1:0] rb_data,
  input  logic [DW-1:0] status_in,
  input  logic [CW-1:0] byte_cnt,
  input  logic [CW-1:0] addr_a,
  input  logic [CW-1:0] addr_b,
  input  logic          int_req,
  input  logic          int_ack,
  output logic          dma_en,
  output logic          int_en,
  output logic          int_pend,
  output logic          int_ius,
  output logic          load_stb,
  output logic          cont_stb,
  output logic          force_rdy_stb,
  output logic          rst_a_tim_stb,
  output logic          rst_b_tim_stb
);
  logic                     live_q;
  logic                     mask_wait;
  logic                     take;
  logic [DW-1:0]            stat_q;
  cmd_t                     cmd;
  logic [NSLOT-1:0][DW-1:0] slots;

  assign cmd_ready = live_q;
  assign rb_valid  = live_q;
  assign take      = cmd_valid && cmd_ready;

  dma_cmd_decode #(.DW(DW)) u_dec (
    .en   (take && !mask_wait),
    .code (cmd_data),
    .cmd  (cmd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q        <= 1'b0;
      mask_wait     <= 1'b0;
      stat_q        <= '0;
      dma_en        <= 1'b0;
      load_stb      <= 1'b0;
      cont_stb      <= 1'b0;
      force_rdy_stb <= 1'b0;
      rst_a_tim_stb <= 1'b0;
      rst_b_tim_stb <= 1'b0;
    end else begin
      live_q <= 1'b1;
      if (cmd.rst_all)        mask_wait <= 1'b0;
      else if (cmd.mask_next) mask_wait <= 1'b1;
      else if (take)          mask_wait <= 1'b0;
      if (cmd.reinit_st) stat_q <= status_in;
      if (cmd.rst_all || cmd.dma_off) dma_en <= 1'b0;
      else if (cmd.dma_on)            dma_en <= 1'b1;
      load_stb      <= cmd.load;
      cont_stb      <= cmd.cont;
      force_rdy_stb <= cmd.force_rdy;
      rst_a_tim_stb <= cmd.rst_a;
      rst_b_tim_stb <= cmd.rst_b;
    end
  end

  localparam int HB = CW / 2;
  always_comb begin
    slots[0] = stat_q;
    slots[1] = DW'(byte_cnt[HB-1:0]);
    slots[2] = DW'(byte_cnt[CW-1:HB]);
    slots[3] = DW'(addr_a[HB-1:0]);
    slots[4] = DW'(addr_a[CW-1:HB]);
    slots[5] = DW'(addr_b[HB-1:0]);
    slots[6] = DW'(addr_b[CW-1:HB]);
  end

  dma_int_flags u_int (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (cmd),
    .int_req  (int_req),
    .int_ack  (int_ack),
    .int_en   (int_en),
    .int_pend (int_pend),
    .int_ius  (int_ius)
  );

  dma_rb_seq #(.DW(DW)) u_rb (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (cmd),
    .mask_load (take && mask_wait),
    .mask_val  (cmd_data),
    .pop       (rb_valid && rb_ready),
    .slots     (slots),
    .rd_byte   (rb_data)
  );
endmodule

// File: rtl/dma_cmd_seq_chk.sv
module dma_cmd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [7:0] cmd_data,
  input logic       mask_wait,
  input logic       int_ack,
  input logic       dma_en,
  input logic       int_en,
  input logic       int_pend,
  input logic       int_ius,
  input logic [4:0] stbs
);
  // R3: at most one strobe at a time
  a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stbs));

  // R3: load strobe only after an accepted load code
  a_r3_load_src: assert property (@(posedge clk) disable iff (!rst_n)
    stbs[0] |-> $past(cmd_valid && !mask_wait && cmd_data == 8'hCF));

  // R6: clear-and-disable empties every interrupt flag
  a_r6_int_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !mask_wait && cmd_data == 8'hA3) |=> (!int_en && !int_pend && !int_ius));

  // R5: in-service only rises on an acknowledge
  a_r5_ius_src: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_ius) |-> $past(int_ack));

  // R13: full reset code turns DMA off
  a_r13_reset_dma: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !mask_wait && cmd_data == 8'hC3) |=> (!dma_en && !int_en));

  // R7: a mask byte never alters DMA enable
  a_r7_mask_not_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && mask_wait) |=> $stable(dma_en));
endmodule

bind dma_cmd_seq dma_cmd_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_data  (cmd_data),
  .mask_wait (mask_wait),
  .int_ack   (int_ack),
  .dma_en    (dma_en),
  .int_en    (int_en),
  .int_pend  (int_pend),
  .int_ius   (int_ius),
  .stbs      ({rst_b_tim_stb, rst_a_tim_stb, force_rdy_stb, cont_stb, load_stb})
);

// File: tb/tb_dma_cmd_seq.sv
module tb_dma_cmd_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [7:0]  cmd_data = '0;
  logic        rb_valid;
  logic        rb_ready = 1'b0;
  logic [7:0]  rb_data;
  logic [7:0]  status_in = 8'h5A;
  logic [15:0] byte_cnt = 16'h1234;
  logic [15:0] addr_a = 16'hABCD;
  logic [15:0] addr_b = 16'h9876;
  logic        int_req = 1'b0;
  logic        int_ack = 1'b0;
  logic        dma_en, int_en, int_pend, int_ius;
  logic        load_stb, cont_stb, force_rdy_stb, rst_a_tim_stb, rst_b_tim_stb;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  dma_cmd_seq dut (.*);

  function automatic logic [4:0] stbs();
    return {rst_b_tim_stb, rst_a_tim_stb, force_rdy_stb, cont_stb, load_stb};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_data  = b;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic rd(input string req, input logic [7:0] exp);
    @(negedge clk);
    chk(req, {24'h0, rb_data}, {24'h0, exp});
    rb_ready = 1'b1;
    @(negedge clk);
    rb_ready = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 flags", {dma_en, int_en, int_pend, int_ius}, 0);
    chk("R1 strobes", {27'h0, stbs()}, 0);
    chk("R1 valid", {rb_valid, cmd_ready}, 2'b11);
    rd("R1 status", 8'h00);
    rd("R8 cnt lo", 8'h34);
    rd("R8 cnt hi", 8'h12);
    rd("R8 a lo", 8'hCD);
    rd("R8 a hi", 8'hAB);
    rd("R8 b lo", 8'h76);
    rd("R8 b hi", 8'h98);
    rd("R8 wrap", 8'h00);
  endtask

  task automatic t_status();
    wr(8'h8B);
    wr(8'hA7);
    rd("R12 status load", 8'h5A);
    rd("R9 after restart", 8'h34);
  endtask

  task automatic t_mask();
    wr(8'hBB);
    wr(8'h87);
    chk("R7 mask not cmd", {31'h0, dma_en}, 0);
    rd("R7 first sel", 8'h5A);
    rd("R8 sparse", 8'h34);
    rd("R8 sparse", 8'h12);
    rd("R8 sparse wrap", 8'h5A);
    wr(8'hBB);
    wr(8'h28);
    rd("R7 gap first", 8'hCD);
    rd("R8 gap next", 8'h76);
    rd("R8 gap wrap", 8'hCD);
  endtask

  task automatic t_force();
    // pointer now at B low
    wr(8'hBF);
    rd("R10 forced status", 8'h5A);
    rd("R10 resumes", 8'h76);
    wr(8'hA7);
    rd("R9 restart", 8'hCD);
  endtask

  task automatic t_zero();
    wr(8'hBB);
    wr(8'h00);
    rd("R11 zero mask", 8'h5A);
    rd("R11 zero mask", 8'h5A);
  endtask

  task automatic t_dma();
    wr(8'h87);
    chk("R2 on", {31'h0, dma_en}, 1);
    wr(8'h83);
    chk("R2 off", {31'h0, dma_en}, 0);
  endtask

  task automatic one_stb(input string req, input logic [7:0] code, input logic [4:0] exp);
    wr(code);
    chk(req, {27'h0, stbs()}, {27'h0, exp});
    @(negedge clk);
    chk({req, " low"}, {27'h0, stbs()}, 0);
  endtask

  task automatic t_strobes();
    one_stb("R3 load", 8'hCF, 5'b00001);
    one_stb("R3 cont", 8'hD3, 5'b00010);
    one_stb("R3 frdy", 8'hB3, 5'b00100);
    one_stb("R3 rsta", 8'hC7, 5'b01000);
    one_stb("R3 rstb", 8'hCB, 5'b10000);
  endtask

  task automatic pulse_req();
    @(negedge clk); int_req = 1'b1;
    @(negedge clk); int_req = 1'b0;
  endtask

  task automatic pulse_ack();
    @(negedge clk); int_ack = 1'b1;
    @(negedge clk); int_ack = 1'b0;
  endtask

  task automatic t_int();
    pulse_req();
    chk("R5 req ignored when off", {31'h0, int_pend}, 0);
    wr(8'hAB);
    chk("R4 enable", {int_en, int_pend, int_ius}, 3'b100);
    pulse_req();
    chk("R5 pending", {int_en, int_pend, int_ius}, 3'b110);
    wr(8'hAB);
    chk("R4 keeps pending", {int_en, int_pend, int_ius}, 3'b110);
    pulse_ack();
    chk("R5 ack", {int_en, int_pend, int_ius}, 3'b101);
    wr(8'hAB);
    chk("R4 keeps ius", {int_en, int_pend, int_ius}, 3'b101);
    pulse_req();
    wr(8'hAF);
    chk("R4 disable", {int_en, int_pend, int_ius}, 3'b011);
    wr(8'hB7);
    chk("R6 reti", {int_en, int_pend, int_ius}, 3'b110);
    pulse_ack();
    wr(8'hA3);
    chk("R6 clear", {int_en, int_pend, int_ius}, 3'b000);
  endtask

  task automatic t_unknown();
    wr(8'hBB);
    wr(8'h06);
    rd("R14 setup", 8'h34);
    wr(8'h87);
    wr(8'hAB);
    wr(8'h00);
    wr(8'hFF);
    chk("R14 flags kept", {dma_en, int_en, int_pend, int_ius}, 4'b1100);
    chk("R14 no strobe", {27'h0, stbs()}, 0);
    rd("R14 seq kept", 8'h12);
  endtask

  task automatic t_c3();
    wr(8'hC3);
    chk("R13 flags", {dma_en, int_en, int_pend, int_ius}, 0);
    rd("R13 status kept", 8'h5A);
    rd("R13 full mask", 8'h34);
    rd("R13 full mask", 8'h12);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_status();
    t_mask();
    t_force();
    t_zero();
    t_dma();
    t_strobes();
    t_int();
    t_unknown();
    t_c3();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule